// File: doc/BRIEF.md
# Arbitrated Fixed-Latency Line Memory

This block is a word-addressed backing store organised as lines of four words, shared by several requesters, with only one access in flight at a time. A requester raises its valid bit with a write flag, a word address and, for a write, one data word, and holds them until it sees a completion code. The low two address bits select the word within a line and the remaining bits select the line. A read delivers the whole addressed line at once. A write replaces one word.

When nobody owns the memory, the requester that presents a request takes ownership; if several arrive in the same cycle, the lowest index wins. The owner sees a wait code until a countdown, loaded with the `LATENCY` parameter, runs out, and then sees a completion code. In that same cycle ownership is dropped and the countdown reloads. The countdown only moves while someone owns the memory. Other requesters keep seeing the wait code, and nothing they present changes the stored data. With `LINE_AW` set to 13 the store holds 8192 lines. The default is smaller so the array stays modest.

Top module: `linemem_arb`

## Requirements
- R1: A word address splits into a line number (address divided by 4, i.e. bits above the low two) and a word position (address modulo 4, the low two bits).
- R2: On a read completion `rd_line` carries all four words of the addressed line, word k in bits [k*WORD_W +: WORD_W].
- R3: A write completion replaces only the addressed word. The other three words of that line keep their values, and the new value is visible to any read that completes in a later cycle.
- R4: When the memory is idle, the requester with a valid request becomes owner; among simultaneous requesters the lowest index wins, and ownership holds until that access completes.
- R5: Status codes per requester are 2 bits: 0 none, 1 wait, 2 ok. The owner sees wait in the claim cycle and the following LATENCY-1 cycles, and ok in cycle LATENCY counted from the claim.
- R6: At completion the owner is released and the countdown reloads. Idle cycles do not advance it, so every transaction takes the same latency however long the gap before it.
- R7: A valid requester that is not the owner sees wait (code 1), and its write does not change the stored data.
- R8: A requester whose valid bit is low sees code 0.
- R9: With LATENCY equal to 0 an access completes in the cycle it is claimed, so one requester can complete on consecutive cycles.
- R10: After reset no requester owns the memory and the first transaction takes the full LATENCY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_REQ | Request present, one bit per requester |
| req_write | input | NUM_REQ | 1 = write one word, 0 = read a line |
| req_addr | input | NUM_REQ*(LINE_AW+2) | Word address per requester, requester i at slice i |
| req_wdata | input | NUM_REQ*WORD_W | Write word per requester |
| rsp_code | output | NUM_REQ*2 | Status per requester: 0 none, 1 wait, 2 ok |
| rd_line | output | 4*WORD_W | Line addressed by the current owner, valid with an ok code on a read |

## Verification
The bench builds two instances. The first has three requesters, sixteen lines and a latency of 3. This makes simultaneous claims, a requester arriving mid-transaction, re-claiming by a waiting requester and idle gaps easy to reach within a few cycles. The second has two requesters and a latency of 0. It exercises same-cycle completion, back-to-back ownership by one requester, and a read in the cycle right after a write.

// File: rtl/linemem_pkg.sv
// Shared types for the arbitrated line memory.
// Assumes a 2-bit status code per requester, decoded by the requesters.
package linemem_pkg;

    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_WAIT = 2'd1,
        RSP_OK   = 2'd2
    } rsp_e;

endpackage

// File: rtl/linemem_owner.sv
// Ownership latch: picks the lowest-index valid requester when idle and
// holds that requester until the access completes.
// Assumes 'done' is only raised while an owner is active.
module linemem_owner #(
    parameter int NUM_REQ = 2,
    parameter int ID_W    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_valid,
    input  logic               done,
    output logic               active_vld,
    output logic [ID_W-1:0]    active_id
);

    logic            own_vld_q;
    logic [ID_W-1:0] own_id_q;
    logic            claim_vld;
    logic [ID_W-1:0] claim_id;

    // Fixed-priority pick of a new owner: lowest index wins.
    always_comb begin
        claim_vld = |req_valid;
        claim_id  = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req_valid[i]) claim_id = ID_W'(i);
        end
    end

    // The held owner takes precedence over any new claim.
    always_comb begin
        active_vld = own_vld_q | claim_vld;
        active_id  = own_vld_q ? own_id_q : claim_id;
    end

    // Latch the owner on claim, drop it at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_vld_q <= 1'b0;
            own_id_q  <= '0;
        end else if (done) begin
            own_vld_q <= 1'b0;
        end else if (active_vld) begin
            own_vld_q <= 1'b1;
            own_id_q  <= active_id;
        end
    end

    AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        own_vld_q && !done |=> own_vld_q && (own_id_q == $past(own_id_q))); // R4

    AST_OWNER_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !own_vld_q); // R6

endmodule

// File: rtl/linemem_countdown.sv
// Latency countdown: starts at LATENCY, steps down once per owned cycle,
// flags expiry at zero and reloads when an owned cycle sees expiry.
// Assumes 'active' is high exactly on cycles when a requester owns the memory.
module linemem_countdown #(
    parameter int LATENCY = 4,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    logic [CNT_W-1:0] cnt_q;

    // Expiry is a pure decode of the counter.
    always_comb expired = (cnt_q == '0);

    // Count only while owned; reload on the completing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(LATENCY);
        end else if (active) begin
            if (expired) cnt_q <= CNT_W'(LATENCY);
            else         cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LATENCY)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        active && !expired |=> cnt_q == $past(cnt_q) - 1'b1); // R5

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/linemem_array.sv
// Line storage: one column array per word position, so a write touches a
// single column and a read gathers all columns of one line.
// Assumes LINE_WORDS is a power of two; the contents have no reset.
module linemem_array #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINE_AW    = 8,
    parameter int OFS_W      = 2
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [LINE_AW-1:0]           wr_line,
    input  logic [OFS_W-1:0]             wr_word,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [LINE_AW-1:0]           rd_idx,
    output logic [LINE_WORDS*WORD_W-1:0] rd_data
);

    localparam int LINES = 1 << LINE_AW;

    for (genvar gk = 0; gk < LINE_WORDS; gk++) begin : g_col
        logic [WORD_W-1:0] col [LINES];

        // Update this column only when the write targets its word position.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_word == OFS_W'(gk))) col[wr_line] <= wr_data;
        end

        // Asynchronous read of the selected line for this column.
        assign rd_data[gk*WORD_W +: WORD_W] = col[rd_idx];
    end

endmodule

// File: rtl/linemem_arb.sv
// Arbitrated fixed-latency line memory top.
// Serves one requester at a time: the owner waits LATENCY cycles, then a
// read returns a full line or a write stores one word, and ownership ends.
// Assumes requesters hold valid, write, address and data stable until ok.
module linemem_arb
    import linemem_pkg::*;
#(
    parameter int NUM_REQ    = 2,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINE_AW    = 8,
    parameter int LATENCY    = 4,
    localparam int OFS_W     = $clog2(LINE_WORDS),
    localparam int ADDR_W    = LINE_AW + OFS_W,
    localparam int LINE_W    = LINE_WORDS * WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ-1:0]        req_write,
    input  logic [NUM_REQ*ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ*WORD_W-1:0] req_wdata,
    output logic [NUM_REQ*2-1:0]      rsp_code,
    output logic [LINE_W-1:0]         rd_line
);

    localparam int ID_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam int CNT_W = (LATENCY > 0) ? $clog2(LATENCY + 1) : 1;

    logic               active_vld;
    logic [ID_W-1:0]    active_id;
    logic               expired;
    logic               done;
    logic [ADDR_W-1:0]  sel_addr;
    logic [WORD_W-1:0]  sel_wdata;
    logic               wr_en;

    linemem_owner #(
        .NUM_REQ (NUM_REQ),
        .ID_W    (ID_W)
    ) owner_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .done       (done),
        .active_vld (active_vld),
        .active_id  (active_id)
    );

    linemem_countdown #(
        .LATENCY (LATENCY),
        .CNT_W   (CNT_W)
    ) count_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active_vld),
        .expired (expired)
    );

    // Completion: an owned cycle whose countdown has run out.
    always_comb done = active_vld && expired;

    // Route the owner's address and data to the store.
    always_comb begin
        sel_addr  = req_addr[int'(active_id)*ADDR_W +: ADDR_W];
        sel_wdata = req_wdata[int'(active_id)*WORD_W +: WORD_W];
        wr_en     = done && req_valid[active_id] && req_write[active_id];
    end

    linemem_array #(
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS),
        .LINE_AW    (LINE_AW),
        .OFS_W      (OFS_W)
    ) array_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_line (sel_addr[ADDR_W-1:OFS_W]),
        .wr_word (sel_addr[OFS_W-1:0]),
        .wr_data (sel_wdata),
        .rd_idx  (sel_addr[ADDR_W-1:OFS_W]),
        .rd_data (rd_line)
    );

    for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_rsp
        rsp_e code;

        // Per-requester status: none, wait, or ok for the completing owner.
        always_comb begin
            if (!req_valid[gi])                                code = RSP_NONE;
            else if (done && (active_id == ID_W'(gi)))         code = RSP_OK;
            else                                               code = RSP_WAIT;
        end

        assign rsp_code[gi*2 +: 2] = code;
    end

endmodule

// File: tb/linemem_arb_tb.sv
`timescale 1ns/1ps
module linemem_arb_tb_top;

    localparam int LAT = 3;
    localparam logic [1:0] C_NONE = 2'd0;
    localparam logic [1:0] C_WAIT = 2'd1;
    localparam logic [1:0] C_OK   = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Instance with three requesters and latency 3
    logic [2:0]   v_i = '0, w_i = '0;
    logic [17:0]  a_i = '0;
    logic [95:0]  d_i = '0;
    logic [5:0]   code_i;
    logic [127:0] line_i;

    // Instance with two requesters and latency 0
    logic [1:0]   v_z = '0, w_z = '0;
    logic [11:0]  a_z = '0;
    logic [63:0]  d_z = '0;
    logic [3:0]   code_z;
    logic [127:0] line_z;

    linemem_arb #(.NUM_REQ(3), .WORD_W(32), .LINE_WORDS(4), .LINE_AW(4), .LATENCY(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(v_i), .req_write(w_i),
        .req_addr(a_i), .req_wdata(d_i), .rsp_code(code_i), .rd_line(line_i));

    linemem_arb #(.NUM_REQ(2), .WORD_W(32), .LINE_WORDS(4), .LINE_AW(4), .LATENCY(0)) dut_z (
        .clk(clk), .rst_n(rst_n), .req_valid(v_z), .req_write(w_z),
        .req_addr(a_z), .req_wdata(d_z), .rsp_code(code_z), .rd_line(line_z));

    logic [31:0] mdl_i [16][4];
    logic [31:0] mdl_z [16][4];

    typedef struct {
        int           cyc;
        int           dut;
        int           port;
        logic [1:0]   code;
        bit           is_line;
        logic [127:0] line;
        string        tag;
    } exp_t;

    exp_t sbq[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    function automatic logic [127:0] pack_line(input logic [31:0] m [4]);
        return {m[3], m[2], m[1], m[0]};
    endfunction

    function automatic void push(input int dut, input int port, input logic [1:0] code,
                                 input bit is_line, input logic [127:0] line, input string tag);
        exp_t e;
        e.cyc = cyc; e.dut = dut; e.port = port; e.code = code;
        e.is_line = is_line; e.line = line; e.tag = tag;
        sbq.push_back(e);
    endfunction

    // Monitor: pops every item due this cycle and compares it with the ports.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            n_cmp++;
            if (e.is_line) begin
                logic [127:0] act;
                act = (e.dut == 0) ? line_i : line_z;
                if (act !== e.line) begin
                    n_bad++;
                    $display("FAIL %s: dut%0d line act=%h exp=%h", e.tag, e.dut, act, e.line);
                end
            end else begin
                logic [1:0] act;
                act = (e.dut == 0) ? code_i[e.port*2 +: 2] : code_z[e.port*2 +: 2];
                if (act !== e.code) begin
                    n_bad++;
                    $display("FAIL %s: dut%0d port%0d code act=%0d exp=%0d",
                             e.tag, e.dut, e.port, act, e.code);
                end
            end
        end
    end

    // One cycle on the three-requester instance, with expected codes.
    task automatic step_i(input logic [2:0] v, input logic [2:0] w, input int a [3],
                          input int d [3], input logic [1:0] e [3], input int rd_ln,
                          input string tag);
        @(posedge clk); #1;
        v_i = v; w_i = w;
        for (int k = 0; k < 3; k++) begin
            a_i[k*6 +: 6]   = a[k][5:0];
            d_i[k*32 +: 32] = d[k];
        end
        for (int k = 0; k < 3; k++) push(0, k, e[k], 0, '0, tag);
        if (rd_ln >= 0) push(0, -1, C_NONE, 1, pack_line(mdl_i[rd_ln]), tag);
        for (int k = 0; k < 3; k++)
            if (e[k] == C_OK && w[k]) mdl_i[a[k] / 4][a[k] % 4] = d[k];
    endtask

    task automatic step_z(input logic [1:0] v, input logic [1:0] w, input int a [2],
                          input int d [2], input logic [1:0] e [2], input int rd_ln,
                          input string tag);
        @(posedge clk); #1;
        v_z = v; w_z = w;
        for (int k = 0; k < 2; k++) begin
            a_z[k*6 +: 6]   = a[k][5:0];
            d_z[k*32 +: 32] = d[k];
        end
        for (int k = 0; k < 2; k++) push(1, k, e[k], 0, '0, tag);
        if (rd_ln >= 0) push(1, -1, C_NONE, 1, pack_line(mdl_z[rd_ln]), tag);
        for (int k = 0; k < 2; k++)
            if (e[k] == C_OK && w[k]) mdl_z[a[k] / 4][a[k] % 4] = d[k];
    endtask

    task automatic idle_i(input string tag);
        step_i(3'b000, 3'b000, '{0, 0, 0}, '{0, 0, 0}, '{C_NONE, C_NONE, C_NONE}, -1, tag);
    endtask

    // Single-requester transaction on dut_i: wait LAT cycles, then ok.
    task automatic txn_i(input int p, input bit wr, input int addr, input int data,
                         input string tag);
        for (int k = 0; k <= LAT; k++) begin
            int a [3];
            int d [3];
            logic [1:0] e [3];
            a = '{0, 0, 0}; d = '{0, 0, 0}; e = '{C_NONE, C_NONE, C_NONE};
            a[p] = addr; d[p] = data;
            e[p] = (k == LAT) ? C_OK : C_WAIT;
            step_i(3'(1 << p), wr ? 3'(1 << p) : 3'b000, a, d, e,
                   (!wr && k == LAT) ? addr / 4 : -1, tag);
        end
    endtask

    task automatic txn_z(input int p, input bit wr, input int addr, input int data,
                         input string tag);
        int a [2];
        int d [2];
        logic [1:0] e [2];
        a = '{0, 0}; d = '{0, 0}; e = '{C_NONE, C_NONE};
        a[p] = addr; d[p] = data; e[p] = C_OK;
        step_z(2'(1 << p), wr ? 2'(1 << p) : 2'b00, a, d, e, wr ? -1 : addr / 4, tag);
    endtask

    task automatic fill_i(input int p, input int ln, input int base);
        for (int k = 0; k < 4; k++) txn_i(p, 1, ln * 4 + k, base + k, "R1 fill write");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 / R8: no owner and no codes after reset
        idle_i("R10 reset idle");
        idle_i("R8 no request");

        // R10 / R5 / R1: first transactions take full latency; fill line 5 word by word
        fill_i(1, 5, 32'h5000);
        // R2: whole line returned on read
        txn_i(0, 0, 5 * 4 + 1, 0, "R2 read full line");

        // R3: single word write leaves neighbours intact
        txn_i(2, 1, 5 * 4 + 2, 32'hCAFE0002, "R3 single word write");
        txn_i(0, 0, 5 * 4 + 3, 0, "R3 read after word write");

        fill_i(0, 9, 32'h9000);
        fill_i(0, 11, 32'hB000);
        fill_i(0, 12, 32'hC000);

        // R4 / R7: p0 and p2 claim together; p1 arrives mid-flight
        for (int c = 0; c < 8; c++) begin
            logic [2:0] v;
            logic [1:0] e [3];
            if (c < 4) begin
                v = (c == 1 || c == 2) ? 3'b111 : 3'b101;
                e[0] = (c == 3) ? C_OK : C_WAIT;
                e[1] = v[1] ? C_WAIT : C_NONE;
                e[2] = C_WAIT;
            end else begin
                v = 3'b100;
                e[0] = C_NONE; e[1] = C_NONE;
                e[2] = (c == 7) ? C_OK : C_WAIT;
            end
            step_i(v, v, '{37, 48, 39}, '{32'hA0, 32'hDEAD, 32'hB2}, e, -1,
                   "R4 R7 contention");
        end
        txn_i(1, 0, 48, 0, "R7 non-owner write ignored");
        txn_i(1, 0, 36, 0, "R4 owner order of writes");

        // R4: simultaneous reads by p1 and p2, lowest index wins
        for (int c = 0; c < 4; c++) begin
            logic [1:0] e [3];
            e[0] = C_NONE;
            e[1] = (c == 3) ? C_OK : C_WAIT;
            e[2] = C_WAIT;
            step_i(3'b110, 3'b000, '{0, 44, 20}, '{0, 0, 0}, e, (c == 3) ? 11 : -1,
                   "R4 tie lowest index");
        end
        idle_i("R8 requests dropped");

        // R6: long idle gap does not shorten the next transaction
        for (int k = 0; k < 6; k++) idle_i("R6 idle gap");
        txn_i(2, 0, 20, 0, "R6 latency after gap");
        txn_i(1, 0, 47, 0, "R6 back-to-back latency");

        // R9: zero latency, same requester completes on consecutive cycles
        for (int k = 0; k < 4; k++) txn_z(0, 1, 12 + k, 32'h3000 + k, "R9 zero-latency write");
        txn_z(1, 0, 13, 0, "R9 zero-latency read");
        step_z(2'b11, 2'b11, '{13, 14}, '{32'h77, 32'h99}, '{C_OK, C_WAIT}, -1,
               "R9 R7 same-cycle claim");
        step_z(2'b10, 2'b00, '{0, 12}, '{0, 0}, '{C_NONE, C_OK}, 3,
               "R3 R9 read sees prior write");
        step_z(2'b00, 2'b00, '{0, 0}, '{0, 0}, '{C_NONE, C_NONE}, -1, "R8 zero-latency idle");

        repeat (2) @(posedge clk);
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: leftover act=%0d exp=0", sbq.size());
        end
        summary();
    end

endmodule